// File: doc/BRIEF.md
# Memory ECC Error Capture Registers

This block sits beside a memory controller and keeps a record of memory faults for software. Every completed memory transaction is reported to it as one event. The event carries the transaction address, who issued it (CPU or DMA), its direction, whether it faulted and the cause of the fault. It also carries, for each 16-bit half of the data word, the check bits read from memory, the syndrome, a single/double error flag and a valid flag.

The block holds two 32-bit registers. The fault address register logs the first faulting transaction and raises a level interrupt. The syndrome register follows the ECC information of every memory read until a fault is logged, and then keeps the values of the read that faulted. Software reads either register through a two-address port. A write strobe to either address clears that register. The port carries no write data, because a write clears the register whatever value is written.

Top module: `mem_err_log`

## Requirements
- R1: After reset both registers read as zero and `irq_o` is low.
- R2: A faulting event (`txn_valid_i` and `txn_err_i`) that arrives while the fault address register's bit 31 is clear loads that register on the next clock edge. The layout is: bit 31 = 1, bit 30 = `txn_cpu_i` (1 CPU, 0 DMA), bit 29 = `txn_write_i` (1 write, 0 read), bit 28 = `txn_ecc_i` (1 ECC error, 0 timeout or overrun), bit 27 = 0, bits 26:0 = `txn_addr_i`.
- R3: Only the first fault is logged. While bit 31 is set, later faulting events leave the fault address register unchanged.
- R4: `irq_o` is a level signal equal to bit 31 of the fault address register, so it stays high until software clears that register.
- R5: A write strobe with `reg_sel_i` = 0 clears every bit of the fault address register on the next edge.
- R6: The syndrome register holds the high half in bits 31:16 and the low half in bits 15:0. Each half is laid out as {valid[15], check[14:8], single[7], syndrome[6:0]}. The single flag is 1 for a correctable single-bit error and 0 for a double-bit error.
- R7: While bit 31 of the fault address register is clear, every read event (`txn_valid_i` with `txn_write_i` = 0) loads both halves of the syndrome register, including the read that faults. Write events leave the syndrome register unchanged.
- R8: While bit 31 of the fault address register is set, the syndrome register ignores all events.
- R9: A write strobe with `reg_sel_i` = 1 clears the syndrome register on the next edge.
- R10: When a clear and an event hit the same register in the same cycle, the clear wins and the event is dropped for that register. The other register behaves as it would without the write.
- R11: `reg_rdata_o` shows the fault address register when `reg_sel_i` = 0 and the syndrome register when `reg_sel_i` = 1, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txn_valid_i | input | 1 | A memory transaction completes this cycle |
| txn_err_i | input | 1 | The transaction faulted |
| txn_cpu_i | input | 1 | 1 = CPU transaction, 0 = DMA |
| txn_write_i | input | 1 | 1 = write, 0 = read |
| txn_ecc_i | input | 1 | Fault cause: 1 = ECC error, 0 = timeout or overrun |
| txn_addr_i | input | 27 | Transaction address |
| hi_vld_i | input | 1 | High half ECC error valid |
| hi_chk_i | input | 7 | High half check bits read from memory |
| hi_sng_i | input | 1 | High half single (1) or double (0) bit error |
| hi_syn_i | input | 7 | High half syndrome |
| lo_vld_i | input | 1 | Low half ECC error valid |
| lo_chk_i | input | 7 | Low half check bits read from memory |
| lo_sng_i | input | 1 | Low half single (1) or double (0) bit error |
| lo_syn_i | input | 7 | Low half syndrome |
| reg_we_i | input | 1 | Write strobe, clears the selected register |
| reg_sel_i | input | 1 | Register select: 0 fault address, 1 syndrome |
| reg_rdata_o | output | 32 | Read data of the selected register |
| irq_o | output | 1 | Level interrupt, high while a fault is logged |

## Verification
A stuck or missed valid bit appears on `irq_o` one cycle after the event that should have set or cleared it. It also appears in the syndrome register: with a missed valid bit the register keeps following reads it should have ignored, and with a stuck valid bit it ignores reads it should have taken. The next readback through the port shows either difference. A wrong clear priority leaves a stale fault address and a raised interrupt after the colliding cycle. A swapped field or half shows up as a wrong bit pattern on the first readback after a capture.

// File: rtl/mem_err_pkg.sv
package mem_err_pkg;
  parameter int unsigned ADDR_W   = 27;
  parameter int unsigned ECC_W    = 7;
  parameter int unsigned REG_W    = 32;
  parameter int unsigned NUM_HALF = 2;

  localparam int unsigned HALF_W = 2 * ECC_W + 2;
  localparam int unsigned PAD_W  = REG_W - 4 - ADDR_W;

  typedef struct packed {
    logic             vld;
    logic [ECC_W-1:0] chk;
    logic             sng;
    logic [ECC_W-1:0] syn;
  } half_t;
endpackage

// File: rtl/mem_err_addr_reg.sv
module mem_err_addr_reg
  import mem_err_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              cap_i,
  input  logic              cpu_i,
  input  logic              wr_i,
  input  logic              ecc_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [REG_W-1:0]  q_o,
  output logic              valid_o
);
  logic [REG_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (clr_i) begin
      q <= '0;
    end else if (cap_i && !q[REG_W-1]) begin
      q <= {1'b1, cpu_i, wr_i, ecc_i, {PAD_W{1'b0}}, addr_i};
    end
  end

  assign q_o     = q;
  assign valid_o = q[REG_W-1];
endmodule

// File: rtl/mem_err_syn_half.sv
module mem_err_syn_half
  import mem_err_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  logic  upd_i,
  input  half_t d_i,
  output half_t q_o
);
  half_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (clr_i) begin
      q <= '0;
    end else if (upd_i) begin
      q <= d_i;
    end
  end

  assign q_o = q;
endmodule

// File: rtl/mem_err_log.sv
module mem_err_log
  import mem_err_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              txn_valid_i,
  input  logic              txn_err_i,
  input  logic              txn_cpu_i,
  input  logic              txn_write_i,
  input  logic              txn_ecc_i,
  input  logic [ADDR_W-1:0] txn_addr_i,
  input  logic              hi_vld_i,
  input  logic [ECC_W-1:0]  hi_chk_i,
  input  logic              hi_sng_i,
  input  logic [ECC_W-1:0]  hi_syn_i,
  input  logic              lo_vld_i,
  input  logic [ECC_W-1:0]  lo_chk_i,
  input  logic              lo_sng_i,
  input  logic [ECC_W-1:0]  lo_syn_i,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  logic [REG_W-1:0] addr_q;
  logic [REG_W-1:0] syn_q;
  logic             err_valid;
  logic             clr_addr, clr_syn, syn_upd;
  half_t            half_d [NUM_HALF];
  half_t            half_q [NUM_HALF];

  assign clr_addr = reg_we_i && !reg_sel_i;
  assign clr_syn  = reg_we_i && reg_sel_i;
  // tracking uses the registered valid, so the faulting read itself is captured
  assign syn_upd  = txn_valid_i && !txn_write_i && !err_valid;

  assign half_d[0] = '{vld: lo_vld_i, chk: lo_chk_i, sng: lo_sng_i, syn: lo_syn_i};
  assign half_d[1] = '{vld: hi_vld_i, chk: hi_chk_i, sng: hi_sng_i, syn: hi_syn_i};

  mem_err_addr_reg i_addr_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_addr),
    .cap_i   (txn_valid_i && txn_err_i),
    .cpu_i   (txn_cpu_i),
    .wr_i    (txn_write_i),
    .ecc_i   (txn_ecc_i),
    .addr_i  (txn_addr_i),
    .q_o     (addr_q),
    .valid_o (err_valid)
  );

  for (genvar g = 0; g < NUM_HALF; g++) begin : g_half
    mem_err_syn_half i_half (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_syn),
      .upd_i  (syn_upd),
      .d_i    (half_d[g]),
      .q_o    (half_q[g])
    );
    assign syn_q[g*HALF_W +: HALF_W] = half_q[g];
  end

  assign reg_rdata_o = reg_sel_i ? syn_q : addr_q;
  assign irq_o       = err_valid;
endmodule

// File: rtl/mem_err_log_chk.sv
module mem_err_log_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        txn_valid_i,
  input logic        txn_err_i,
  input logic        txn_write_i,
  input logic        reg_we_i,
  input logic        reg_sel_i,
  input logic        irq_o,
  input logic [31:0] addr_q,
  input logic [31:0] syn_q
);
  // R2
  first_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_i && txn_err_i && !irq_o && !(reg_we_i && !reg_sel_i) |=> irq_o);

  // R3
  first_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !(reg_we_i && !reg_sel_i) |=> irq_o && $stable(addr_q));

  // R5
  addr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && !reg_sel_i |=> !irq_o && addr_q == 32'h0);

  // R8
  syn_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !(reg_we_i && reg_sel_i) |=> $stable(syn_q));

  // R7
  syn_write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(txn_valid_i && !txn_write_i) && !(reg_we_i && reg_sel_i) |=> $stable(syn_q));

  // R9
  syn_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_sel_i |=> syn_q == 32'h0);

  // R2
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_q[27] == 1'b0);
endmodule

bind mem_err_log mem_err_log_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .txn_valid_i (txn_valid_i),
  .txn_err_i   (txn_err_i),
  .txn_write_i (txn_write_i),
  .reg_we_i    (reg_we_i),
  .reg_sel_i   (reg_sel_i),
  .irq_o       (irq_o),
  .addr_q      (addr_q),
  .syn_q       (syn_q)
);

// File: tb/test_mem_err_log.sv
module test_mem_err_log;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        txn_valid_i = 1'b0, txn_err_i = 1'b0, txn_cpu_i = 1'b0;
  logic        txn_write_i = 1'b0, txn_ecc_i = 1'b0;
  logic [26:0] txn_addr_i = '0;
  logic [15:0] hi_w = '0, lo_w = '0;
  logic        reg_we_i = 1'b0;
  logic        drv_sel = 1'b0, mon_sel = 1'b0, mon_busy = 1'b0;
  logic        reg_sel_i;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_a = '0, exp_s = '0;
  logic [31:0] q_a[$];
  logic [31:0] q_s[$];
  string       q_tag[$];

  assign reg_sel_i = mon_busy ? mon_sel : drv_sel;

  always #(CLK_P/2) clk_i = ~clk_i;

  mem_err_log i_mem_err_log (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .txn_valid_i(txn_valid_i), .txn_err_i(txn_err_i), .txn_cpu_i(txn_cpu_i),
    .txn_write_i(txn_write_i), .txn_ecc_i(txn_ecc_i), .txn_addr_i(txn_addr_i),
    .hi_vld_i(hi_w[15]), .hi_chk_i(hi_w[14:8]), .hi_sng_i(hi_w[7]), .hi_syn_i(hi_w[6:0]),
    .lo_vld_i(lo_w[15]), .lo_chk_i(lo_w[14:8]), .lo_sng_i(lo_w[7]), .lo_syn_i(lo_w[6:0]),
    .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  task automatic cmp(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  // monitor: reads both registers through the port and pops the scoreboard
  initial begin
    forever begin
      wait (q_tag.size() > 0);
      mon_busy = 1'b1;
      mon_sel  = 1'b0;
      #1 cmp(q_tag[0], "addr reg", reg_rdata_o, q_a[0]);
      cmp(q_tag[0], "irq", {31'b0, irq_o}, {31'b0, q_a[0][31]});
      mon_sel  = 1'b1;
      #1 cmp(q_tag[0], "syndrome reg", reg_rdata_o, q_s[0]);
      mon_busy = 1'b0;
      void'(q_a.pop_front());
      void'(q_s.pop_front());
      void'(q_tag.pop_front());
    end
  end

  // driver: one cycle of stimulus, expected values from the requirements
  task automatic step(input string tag, input logic tv, input logic terr, input logic twr,
                      input logic tcpu, input logic tecc, input logic [26:0] taddr,
                      input logic [15:0] hi, input logic [15:0] lo,
                      input logic we, input logic sel);
    logic [31:0] na, ns;
    @(negedge clk_i);
    txn_valid_i = tv; txn_err_i = terr; txn_write_i = twr; txn_cpu_i = tcpu;
    txn_ecc_i = tecc; txn_addr_i = taddr; hi_w = hi; lo_w = lo;
    reg_we_i = we; drv_sel = sel;
    na = exp_a;
    ns = exp_s;
    if (we && !sel) na = '0;
    else if (tv && terr && !exp_a[31]) na = {1'b1, tcpu, twr, tecc, 1'b0, taddr};
    if (we && sel) ns = '0;
    else if (tv && !twr && !exp_a[31]) ns = {hi, lo};
    exp_a = na;
    exp_s = ns;
    @(posedge clk_i);
    #1;
    txn_valid_i = 1'b0; txn_err_i = 1'b0; reg_we_i = 1'b0;
    q_a.push_back(exp_a);
    q_s.push_back(exp_s);
    q_tag.push_back(tag);
    wait (q_tag.size() == 0);
  endtask

  initial begin
    #(CLK_P * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    // R1: reset state
    cmp("R1", "addr reg", reg_rdata_o, 32'h0);
    cmp("R1", "irq", {31'b0, irq_o}, 32'h0);
    drv_sel = 1'b1;
    #1 cmp("R1", "syndrome reg", reg_rdata_o, 32'h0);
    drv_sel = 1'b0;
    rst_ni = 1'b1;
    // R11: combinational select visible in the same cycle
    step("R11", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 27'h0000100, 16'h8A95, 16'h1203, 1'b0, 1'b0);
    drv_sel = 1'b1;
    #1 cmp("R11", "mux sel=1", reg_rdata_o, 32'h8A951203);
    drv_sel = 1'b0;
    // R6 R7: clean read tracked, both halves in place
    step("R6", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 27'h0000200, 16'h7F00, 16'h00FF, 1'b0, 1'b0);
    // R7: write transaction ignored by syndrome reg
    step("R7", 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 27'h0000300, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0);
    // R2 R4: faulting CPU read, ECC cause
    step("R2", 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 27'h5A5A5A5, 16'h81C3, 16'h0000, 1'b0, 1'b0);
    // R3: second fault not logged; R8 syndrome frozen
    step("R3", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 27'h1234567, 16'h0101, 16'h0202, 1'b0, 1'b0);
    step("R8", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 27'h0000001, 16'h3333, 16'h4444, 1'b0, 1'b0);
    // R9: clear syndrome, address stays
    step("R9", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 27'h0, 16'h0, 16'h0, 1'b1, 1'b1);
    step("R8", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 27'h0000002, 16'h5555, 16'h6666, 1'b0, 1'b0);
    // R5 R4: clear address register, irq drops
    step("R5", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 27'h0, 16'h0, 16'h0, 1'b1, 1'b0);
    step("R7", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 27'h0000004, 16'h2A2A, 16'h5454, 1'b0, 1'b0);
    // R10: fault collides with address clear, fault dropped, syndrome still tracks
    step("R10", 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 27'h7FFFFFF, 16'h9999, 16'h1111, 1'b1, 1'b0);
    // R10: read collides with syndrome clear, fault still logged
    step("R10", 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 27'h0ABCDEF, 16'hAAAA, 16'hBBBB, 1'b1, 1'b1);
    step("R5", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 27'h0, 16'h0, 16'h0, 1'b1, 1'b0);
    // R2: DMA write, timeout cause, top address; syndrome must not move
    step("R2", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 27'h7FFFFFF, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0);
    step("R4", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 27'h0, 16'h0, 16'h0, 1'b0, 1'b0);
    step("R5", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 27'h0, 16'h0, 16'h0, 1'b1, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule